// File: doc/BRIEF.md
# Streaming Gradient Edge Detector

This block sits in a raster video path and turns RGB pixels into a binary edge map at one pixel per clock. Each incoming pixel is reduced to an 8-bit luminance value. Two row stores keep the luminance of the two rows above, so a 3x3 neighbourhood is available for every pixel. The neighbourhood is convolved with a horizontal and a vertical derivative kernel. The sum of the absolute responses is compared against a threshold, and the result is either full scale or zero.

The row length is not configured. It is taken from the length of each data-enable run. The row count restarts on every vertical sync. Horizontal sync, vertical sync and data-enable come out of the block three cycles after they enter, and the edge value travels with them on the same cycle. A one-bit selector picks the kernel family. The selector and the threshold are taken only while vertical sync is high, so one frame is always filtered with one setting.

Top module: `edge_stream`

## Requirements
- R1: Luminance is computed per pixel as (77*R + 150*G + 29*B) >> 8, using the 8-bit red, green and blue inputs.
- R2: With `in_mode` = 0 (centre-weighted), Gx = sum over rows of w*(right - left) and Gy = sum over columns of w*(top - bottom). The weights w are 1, 2, 1, with the weight of 2 on the middle row or column.
- R3: With `in_mode` = 1 (uniform), the same differences are formed with weights 1, 1, 1 on every row and column.
- R4: With magnitude M = |Gx| + |Gy|, clamped to the largest value of the threshold width, `out_edge` is 8'hFF when M >= threshold and 8'h00 otherwise. A threshold of 0 marks every complete window as an edge.
- R5: The output pixel at row r, column c of a frame uses input rows r-2..r and columns c-2..c. It is 8'h00 when r < 2 or c < 2. `out_edge` is 8'h00 whenever `out_de` is low.
- R6: `out_hs`, `out_vs` and `out_de` equal `in_hs`, `in_vs` and `in_de` from exactly three clocks earlier. The output pixels keep the order and the count of the input pixels.
- R7: `in_mode` and `in_thresh` are captured only in cycles with `in_vs` high. Changes made while `in_vs` is low have no effect on the frame in progress.
- R8: The column position restarts at every rising data-enable run and the row position restarts while vertical sync is high. Frames of different widths are therefore filtered correctly without reconfiguration.
- R9: While `rst_n` is low, all outputs are 0 whatever the inputs do. They stay 0 after reset until the delayed inputs arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_r | input | 8 | Red component |
| in_g | input | 8 | Green component |
| in_b | input | 8 | Blue component |
| in_hs | input | 1 | Horizontal sync in |
| in_vs | input | 1 | Vertical sync in; configuration is taken while high |
| in_de | input | 1 | Active pixel qualifier |
| in_mode | input | 1 | Kernel family: 0 centre-weighted, 1 uniform |
| in_thresh | input | 11 | Edge threshold on the magnitude |
| out_hs | output | 1 | Horizontal sync, delayed by 3 |
| out_vs | output | 1 | Vertical sync, delayed by 3 |
| out_de | output | 1 | Data-enable, delayed by 3 |
| out_edge | output | 8 | 8'hFF for an edge, 8'h00 otherwise |

## Verification
A vertical step separates the two kernel families only by the size of the response. A linear ramp does separate them: at a threshold of 210 the centre-weighted response (240) is above it and the uniform response (180) is below it. A horizontal step exercises the vertical kernel. A flat field with a threshold of 0 leaves only the border rule visible. A colour pattern with unequal channels exposes any error in the luminance weights. A vertical step at thresholds of 1020 and 1021 pins the inclusive compare. Frames 10 and 5 pixels wide show that the row length follows the data-enable run. A frame whose settings change in its second row shows that the settings are held for the whole frame.

// File: rtl/edge_pkg.sv
package edge_pkg;
   typedef enum logic {
      KER_CENTER  = 1'b0,
      KER_UNIFORM = 1'b1
   } kernel_e;

   localparam int unsigned WIN = 3;
endpackage

// File: rtl/gray_conv.sv
module gray_conv #(
   parameter int unsigned PIX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIX_W-1:0] r,
   input  logic [PIX_W-1:0] g,
   input  logic [PIX_W-1:0] b,
   output logic [PIX_W-1:0] gray
);
   localparam int unsigned SW = PIX_W + 8;

   logic [SW-1:0] sum;

   // luma weights sum to 256, so the shifted result always fits PIX_W bits
   always_comb sum = SW'(77) * SW'(r) + SW'(150) * SW'(g) + SW'(29) * SW'(b);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gray <= '0;
      else        gray <= PIX_W'(sum >> 8);
   end
endmodule

// File: rtl/line_store.sv
module line_store #(
   parameter int unsigned DEPTH = 1024,
   parameter int unsigned W     = 8,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] mem [DEPTH];

   // read returns the sample stored one row earlier at this column
   assign rdata = mem[addr];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end
endmodule

// File: rtl/grad_kernel.sv
module grad_kernel
   import edge_pkg::*;
#(
   parameter int unsigned PIX_W = 8,
   parameter int unsigned MAG_W = 11
) (
   input  kernel_e                           mode,
   input  logic [WIN-1:0][WIN-1:0][PIX_W-1:0] win,
   output logic [MAG_W-1:0]                  mag
);
   localparam int unsigned SW     = PIX_W + 4;
   localparam int unsigned MAGMAX = (1 << MAG_W) - 1;

   if (MAG_W < PIX_W) begin : g_bad_mag
      $error("grad_kernel: MAG_W must be at least PIX_W");
   end

   logic signed [SW-1:0] gx, gy, wgt;
   logic [SW-1:0] ax, ay, full;

   always_comb begin
      gx = '0;
      gy = '0;
      for (int i = 0; i < WIN; i++) begin
         wgt = (i == 1 && mode == KER_CENTER) ? SW'(2) : SW'(1);
         gx  = gx + wgt * (SW'(win[i][WIN-1]) - SW'(win[i][0]));
         gy  = gy + wgt * (SW'(win[0][i]) - SW'(win[WIN-1][i]));
      end
      ax   = gx[SW-1] ? SW'(-gx) : SW'(gx);
      ay   = gy[SW-1] ? SW'(-gy) : SW'(gy);
      full = ax + ay;
   end

   if (MAG_W >= SW) begin : g_wide
      assign mag = MAG_W'(full);
   end else begin : g_clamp
      assign mag = (full > SW'(MAGMAX)) ? MAG_W'(MAGMAX) : full[MAG_W-1:0];
   end
endmodule

// File: rtl/edge_stream.sv
module edge_stream
   import edge_pkg::*;
#(
   parameter int unsigned PIX_W    = 8,
   parameter int unsigned LINE_MAX = 1024,
   parameter int unsigned ROW_MAX  = 1024,
   parameter int unsigned MAG_W    = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIX_W-1:0] in_r,
   input  logic [PIX_W-1:0] in_g,
   input  logic [PIX_W-1:0] in_b,
   input  logic             in_hs,
   input  logic             in_vs,
   input  logic             in_de,
   input  logic             in_mode,
   input  logic [MAG_W-1:0] in_thresh,
   output logic             out_hs,
   output logic             out_vs,
   output logic             out_de,
   output logic [PIX_W-1:0] out_edge
);
   localparam int unsigned CW      = $clog2(LINE_MAX + 1);
   localparam int unsigned RW      = $clog2(ROW_MAX + 1);
   localparam int unsigned AW      = $clog2(LINE_MAX);
   localparam int unsigned MAG_CAP = 8 * ((1 << PIX_W) - 1);

   if (LINE_MAX < 3) begin : g_bad_line
      $error("edge_stream: LINE_MAX must be at least 3");
   end
   if (ROW_MAX < 3) begin : g_bad_row
      $error("edge_stream: ROW_MAX must be at least 3");
   end

   // ---------------- stage 1: luminance, sync delay, frame settings
   logic [PIX_W-1:0] gray;
   logic             hs1, vs1, de1;
   logic [MAG_W-1:0] th_q;
   kernel_e          mode_q;

   gray_conv #(.PIX_W(PIX_W)) u_gray (
      .clk, .rst_n, .r(in_r), .g(in_g), .b(in_b), .gray
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {hs1, vs1, de1} <= '0;
         th_q            <= '0;
         mode_q          <= KER_CENTER;
      end else begin
         {hs1, vs1, de1} <= {in_hs, in_vs, in_de};
         if (in_vs) begin
            th_q   <= in_thresh;
            mode_q <= kernel_e'(in_mode);
         end
      end
   end

   // ---------------- stage 2: raster position, row stores, window
   logic [CW-1:0] col_q;
   logic [RW-1:0] row_q;
   logic          de_prev, ok2, hs2, vs2, de2;
   logic          lb_we;
   logic [AW-1:0] lb_addr;
   logic [PIX_W-1:0] taps [WIN];
   logic [WIN-1:0][WIN-1:0][PIX_W-1:0] win;

   assign taps[0] = gray;
   assign lb_we   = de1 && (col_q < CW'(LINE_MAX));
   assign lb_addr = col_q[AW-1:0];

   for (genvar k = 0; k < WIN - 1; k++) begin : g_row
      line_store #(.DEPTH(LINE_MAX), .W(PIX_W)) u_ls (
         .clk, .we(lb_we), .addr(lb_addr), .wdata(taps[k]), .rdata(taps[k+1])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q   <= '0;
         row_q   <= '0;
         de_prev <= 1'b0;
         ok2     <= 1'b0;
         {hs2, vs2, de2} <= '0;
         win     <= '0;
      end else begin
         {hs2, vs2, de2} <= {hs1, vs1, de1};
         de_prev <= de1;
         ok2     <= de1 && (row_q >= RW'(2)) && (col_q >= CW'(2))
                    && (col_q < CW'(LINE_MAX));
         if (de1) begin
            if (col_q != CW'(LINE_MAX)) col_q <= col_q + 1'b1;
            for (int i = 0; i < WIN; i++) begin
               win[i][0] <= win[i][1];
               win[i][1] <= win[i][2];
               win[i][2] <= taps[WIN-1-i];
            end
         end else begin
            col_q <= '0;
         end
         if (vs1) row_q <= '0;
         else if (de_prev && !de1 && row_q != RW'(ROW_MAX)) row_q <= row_q + 1'b1;
      end
   end

   // ---------------- stage 3: gradient, threshold, output
   logic [MAG_W-1:0] mag;

   grad_kernel #(.PIX_W(PIX_W), .MAG_W(MAG_W)) u_grad (
      .mode(mode_q), .win, .mag
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {out_hs, out_vs, out_de} <= '0;
         out_edge <= '0;
      end else begin
         {out_hs, out_vs, out_de} <= {hs2, vs2, de2};
         out_edge <= (ok2 && mag >= th_q) ? '1 : '0;
      end
   end

   // ---------------- checks
   logic [1:0] warm;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          warm <= '0;
      else if (warm != 2'd3) warm <= warm + 2'd1;
   end

   assert_sync_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd3) |-> (out_de == $past(in_de, 3) && out_hs == $past(in_hs, 3)
                          && out_vs == $past(in_vs, 3)));

   assert_edge_binary_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_edge == '0) || (out_edge == '1));

   assert_blank_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !out_de |-> (out_edge == '0));

   assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vs |=> ($stable(th_q) && $stable(mode_q)));

   assert_mag_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(mag) <= MAG_CAP));

   assert_col_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lb_we |-> (32'(lb_addr) < LINE_MAX));
endmodule

// File: tb/edge_stream_bench.sv
module edge_stream_bench;
   localparam int NVEC = 10;
   localparam int CAPN = 64;

   // fields: [18] mode, [17:7] threshold, [6:4] pattern, [3:0] width
   localparam logic [18:0] VECS [NVEC] = '{
      {1'b0, 11'd200,  3'd1, 4'd8},
      {1'b1, 11'd200,  3'd1, 4'd8},
      {1'b0, 11'd1020, 3'd1, 4'd8},
      {1'b0, 11'd1021, 3'd1, 4'd8},
      {1'b0, 11'd210,  3'd3, 4'd8},
      {1'b1, 11'd210,  3'd3, 4'd8},
      {1'b0, 11'd0,    3'd0, 4'd8},
      {1'b1, 11'd300,  3'd4, 4'd8},
      {1'b0, 11'd100,  3'd2, 4'd10},
      {1'b1, 11'd90,   3'd2, 4'd5}
   };
   localparam string VTAG [NVEC] = '{
      "R2", "R3", "R4", "R4", "R2", "R3", "R5", "R1", "R8", "R8"
   };

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n;
   logic [7:0]  in_r, in_g, in_b;
   logic        in_hs, in_vs, in_de, in_mode;
   logic [10:0] in_thresh;
   logic        out_hs, out_vs, out_de;
   logic [7:0]  out_edge;

   edge_stream u_edge_stream (
      .clk, .rst_n, .in_r, .in_g, .in_b, .in_hs, .in_vs, .in_de,
      .in_mode, .in_thresh, .out_hs, .out_vs, .out_de, .out_edge
   );

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // ---------------- monitor, sampled at the falling edge
   logic [7:0] cap [CAPN];
   int capn = 0, armed = 0, sync_bad = 0, blank_bad = 0;
   logic [2:0] h0 = '0, h1 = '0, h2 = '0, h3 = '0;

   always @(negedge clk) begin
      h3 = h2; h2 = h1; h1 = h0; h0 = {in_hs, in_vs, in_de};
      if (!rst_n) armed = 0;
      else begin
         if (armed < 4) armed++;
         else if ({out_hs, out_vs, out_de} !== h3) sync_bad++;
         if (!out_de && out_edge != 8'h00) blank_bad++;
         if (out_vs) capn = 0;
         else if (out_de) begin
            if (capn < CAPN) cap[capn] = out_edge;
            capn++;
         end
      end
   end

   // ---------------- reference model
   function automatic logic [23:0] pix_of(int pat, int r, int c);
      int v;
      case (pat)
         0: v = 100;
         1: v = (c >= 4) ? 255 : 0;
         2: v = (r >= 3) ? 255 : 0;
         3: v = 25 * c + 5 * r;
         default:
            return {8'((r * 53 + c * 17) & 255), 8'((r * 29 + c * 71) & 255),
                    8'((r * 91 + c * 13) & 255)};
      endcase
      return {8'(v), 8'(v), 8'(v)};
   endfunction

   function automatic int lum(int pat, int r, int c);
      logic [23:0] p = pix_of(pat, r, c);
      int s = 77 * int'(p[23:16]) + 150 * int'(p[15:8]) + 29 * int'(p[7:0]);
      return s >> 8;
   endfunction

   function automatic int ref_edge(int mode, int th, int pat, int r, int c);
      int gx = 0, gy = 0, m;
      if (r < 2 || c < 2) return 0;
      for (int i = 0; i < 3; i++) begin
         int wt = (i == 1 && mode == 0) ? 2 : 1;
         gx += wt * (lum(pat, r - 2 + i, c) - lum(pat, r - 2 + i, c - 2));
         gy += wt * (lum(pat, r - 2, c - 2 + i) - lum(pat, r, c - 2 + i));
      end
      m = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
      if (m > 2047) m = 2047;
      return (m >= th) ? 255 : 0;
   endfunction

   // ---------------- stimulus
   task automatic drive(input logic hs, input logic vs, input logic de,
                        input logic [23:0] p);
      @(posedge clk); #2;
      in_hs = hs; in_vs = vs; in_de = de;
      {in_r, in_g, in_b} = p;
   endtask

   task automatic run_frame(input int mode, input int th, input int pat,
                            input int w, input bit swap, input string req);
      int h = 6, bad = 0, br = 0, bc = 0, ba = 0, be = 0;
      in_mode   = mode[0];
      in_thresh = 11'(th);
      repeat (3) drive(1'b0, 1'b1, 1'b0, '0);
      repeat (3) drive(1'b0, 1'b0, 1'b0, '0);
      sync_bad  = 0;
      blank_bad = 0;
      for (int r = 0; r < h; r++) begin
         for (int c = 0; c < w; c++) begin
            drive(1'b0, 1'b0, 1'b1, pix_of(pat, r, c));
            if (swap && r == 1 && c == 0) begin
               in_thresh = 11'd0;
               in_mode   = ~mode[0];
            end
         end
         drive(1'b1, 1'b0, 1'b0, '0);
         repeat (3) drive(1'b0, 1'b0, 1'b0, '0);
      end
      repeat (6) drive(1'b0, 1'b0, 1'b0, '0);
      @(negedge clk);
      chk(capn == w * h, "R6", $sformatf("%s pixel count", req), capn, w * h);
      for (int r = 0; r < h; r++)
         for (int c = 0; c < w; c++) begin
            int e = ref_edge(mode, th, pat, r, c);
            int a = int'(cap[(r * w + c) % CAPN]);
            if (a != e && bad == 0) begin br = r; bc = c; ba = a; be = e; end
            if (a != e) bad++;
         end
      chk(bad == 0, req, $sformatf("mode%0d th%0d pat%0d first bad pixel r%0d c%0d",
          mode, th, pat, br, bc), ba, be);
      chk(sync_bad == 0, "R6", "sync/enable three-cycle delay mismatches", sync_bad, 0);
      chk(blank_bad == 0, "R5", "nonzero edge outside data-enable", blank_bad, 0);
   endtask

   initial begin
      rst_n = 1'b0;
      in_mode = 1'b0; in_thresh = '0;
      // R9: outputs held at zero during reset while inputs are busy
      repeat (4) drive(1'b1, 1'b1, 1'b1, 24'hFFFFFF);
      @(negedge clk);
      chk({out_hs, out_vs, out_de, out_edge} == '0, "R9", "outputs in reset",
          int'({out_hs, out_vs, out_de, out_edge}), 0);
      drive(1'b0, 1'b0, 1'b0, '0);
      rst_n = 1'b1;
      repeat (2) drive(1'b0, 1'b0, 1'b0, '0);
      @(negedge clk);
      chk({out_hs, out_vs, out_de, out_edge} == '0, "R9", "outputs after reset",
          int'({out_hs, out_vs, out_de, out_edge}), 0);

      for (int v = 0; v < NVEC; v++)
         run_frame(int'(VECS[v][18]), int'(VECS[v][17:7]), int'(VECS[v][6:4]),
                   int'(VECS[v][3:0]), 1'b0, VTAG[v]);

      // R7: threshold and mode changed inside a frame must not take effect
      run_frame(0, 1020, 1, 8, 1'b1, "R7");
      // R7: the changed values apply from the next frame
      run_frame(1, 0, 0, 8, 1'b0, "R7");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R6 watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule